// File: doc/BRIEF.md
# Program Memory Mode Address Decoder

This block sits on the fetch and table-access path of a small processor core. It decides, for each byte address the core issues, whether the access is served by on-chip flash or sent to the external memory bus. A 2-bit memory mode setting picks one of four address maps. Two per-device boundaries, the end of the boot block and the end of on-chip memory, are fixed at build time as parameters.

The address is captured on the clock edge where `accessValid` is high. In the following cycle the block decodes it and drives several outputs: the internal/external route, the active-low external chip enable, and a flag that tells the read path to return zero for an unmapped internal read. It also drives pin ownership: the shared bus pins either belong to the general I/O ports, or are held by the bus logic. When the bus logic holds them they are either active or parked idle. In the two split maps, the bus-disable input decides who owns the pins while execution is internal. When no access was captured on the previous edge, the block treats execution as internal.

Top module: `memModeDecoder`

## Requirements
- R1: After reset, with no access yet captured, `selExternal`=0, `chipEnN`=1 and `readZero`=0.
- R2: Mode code 2'b11 (internal only) never routes external. An access above `CHIP_END` raises `readZero`. `pinOwnIo`=1 whatever `busDisable` is.
- R3: Mode code 2'b10 (external only) routes every address from 0 to 1FFFFFh external. `pinOwnIo`=0 and `pinParked`=0 whatever `busDisable` is.
- R4: Mode code 2'b01 (boot split) routes addresses up to and including `BOOT_END` internal and every higher address external.
- R5: Mode code 2'b00 (extended) routes addresses up to and including `CHIP_END` internal and every higher address external.
- R6: `chipEnN` is low exactly when the decoded access is routed external.
- R7: In modes 2'b01 and 2'b00, while the access is internal or no access is active, `busDisable`=1 gives `pinOwnIo`=1 and `pinParked`=0. `busDisable`=0 gives `pinOwnIo`=0 and `pinParked`=1, which means address/data are tri-stated and the strobes are inactive.
- R8: In modes 2'b01 and 2'b00, an access routed external has `pinOwnIo`=0 and `pinParked`=0 whatever `busDisable` is.
- R9: The outputs decode the address captured on the previous rising edge with `accessValid`=1. If `accessValid` was 0 on that edge, the outputs take the idle (internal, no zero-forcing) state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| accessValid | input | 1 | Capture `accessAddr` on this edge |
| accessAddr | input | ADDR_W | Byte address of the access |
| memMode | input | 2 | Address map select (11 int-only, 10 ext-only, 01 boot split, 00 extended) |
| busDisable | input | 1 | Hands pins to I/O during internal execution in split maps |
| selExternal | output | 1 | Access routed to the external bus |
| chipEnN | output | 1 | External chip enable, active low |
| readZero | output | 1 | Force read data to zero (unmapped internal read) |
| pinOwnIo | output | 1 | Bus pins act as general I/O |
| pinParked | output | 1 | Bus pins held idle by the bus logic |

## Verification
Two decisions can land in the same cycle: routing an access across a boundary, and handing the pins over under `busDisable`. The map select can also change in the same cycle as a captured access. The bench steps each map through the accesses on both sides of each boundary, with `busDisable` at both values, and mixes in idle cycles. A behavioural model judges route, chip enable, zero-forcing and pin ownership together on every clock, so a pin decision that is wrong only on the external side of a boundary is caught.

// File: rtl/memModePkg.sv
package memModePkg;
  typedef enum logic [1:0] {
    MODE_EXTENDED  = 2'b00,
    MODE_BOOTSPLIT = 2'b01,
    MODE_EXTONLY   = 2'b10,
    MODE_INTONLY   = 2'b11
  } memMode_e;

  typedef struct packed {
    logic loadAddr;
  } dpStrobe_t;
endpackage

// File: rtl/memModeDatapath.sv
module memModeDatapath
  import memModePkg::*;
#(
  parameter int ADDR_W = 21,
  parameter logic [ADDR_W-1:0] BOOT_END = 'h0007FF,
  parameter logic [ADDR_W-1:0] CHIP_END = 'h00FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] accessAddr,
  output logic              aboveBoot,
  output logic              aboveChip
);
  logic [ADDR_W-1:0] addrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrQ <= '0;
    else if (strb.loadAddr) addrQ <= accessAddr;
  end

  assign aboveBoot = addrQ > BOOT_END;
  assign aboveChip = addrQ > CHIP_END;
endmodule

// File: rtl/memModeCtrl.sv
module memModeCtrl
  import memModePkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      accessValid,
  input  logic [1:0] memMode,
  input  logic      busDisable,
  input  logic      aboveBoot,
  input  logic      aboveChip,
  output dpStrobe_t strb,
  output logic      selExternal,
  output logic      chipEnN,
  output logic      readZero,
  output logic      pinOwnIo,
  output logic      pinParked
);
  logic activeQ;
  logic routeExt;
  memMode_e modeSel;

  assign modeSel = memMode_e'(memMode);
  assign strb.loadAddr = accessValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) activeQ <= 1'b0;
    else activeQ <= accessValid;
  end

  always_comb begin
    routeExt  = 1'b0;
    readZero  = 1'b0;
    pinOwnIo  = 1'b0;
    pinParked = 1'b0;
    case (modeSel)
      MODE_INTONLY: begin
        readZero = activeQ & aboveChip;
        pinOwnIo = 1'b1;
      end
      MODE_EXTONLY: begin
        routeExt = activeQ;
      end
      MODE_BOOTSPLIT: begin
        routeExt  = activeQ & aboveBoot;
        pinOwnIo  = !routeExt & busDisable;
        pinParked = !routeExt & !busDisable;
      end
      default: begin
        routeExt  = activeQ & aboveChip;
        pinOwnIo  = !routeExt & busDisable;
        pinParked = !routeExt & !busDisable;
      end
    endcase
  end

  assign selExternal = routeExt;
  assign chipEnN     = !routeExt;
endmodule

// File: rtl/memModeDecoder.sv
module memModeDecoder
  import memModePkg::*;
#(
  parameter int ADDR_W = 21,
  parameter logic [ADDR_W-1:0] BOOT_END = 'h0007FF,
  parameter logic [ADDR_W-1:0] CHIP_END = 'h00FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accessValid,
  input  logic [ADDR_W-1:0] accessAddr,
  input  logic [1:0]        memMode,
  input  logic              busDisable,
  output logic              selExternal,
  output logic              chipEnN,
  output logic              readZero,
  output logic              pinOwnIo,
  output logic              pinParked
);
  dpStrobe_t strb;
  logic aboveBoot;
  logic aboveChip;

  memModeDatapath #(.ADDR_W(ADDR_W), .BOOT_END(BOOT_END), .CHIP_END(CHIP_END)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .accessAddr(accessAddr),
    .aboveBoot(aboveBoot), .aboveChip(aboveChip)
  );

  memModeCtrl ctl (
    .clk(clk), .rstN(rstN), .accessValid(accessValid), .memMode(memMode),
    .busDisable(busDisable), .aboveBoot(aboveBoot), .aboveChip(aboveChip),
    .strb(strb), .selExternal(selExternal), .chipEnN(chipEnN),
    .readZero(readZero), .pinOwnIo(pinOwnIo), .pinParked(pinParked)
  );
endmodule

// File: rtl/memModeDecoderChk.sv
module memModeDecoderChk #(
  parameter int ADDR_W = 21,
  parameter logic [ADDR_W-1:0] BOOT_END = 'h0007FF,
  parameter logic [ADDR_W-1:0] CHIP_END = 'h00FFFF
) (
  input logic              clk,
  input logic              rstN,
  input logic              accessValid,
  input logic [ADDR_W-1:0] accessAddr,
  input logic [1:0]        memMode,
  input logic              busDisable,
  input logic              selExternal,
  input logic              chipEnN,
  input logic              readZero,
  input logic              pinOwnIo,
  input logic              pinParked
);
  a_r6_ce_only_external: assert property (@(posedge clk) disable iff (!rstN)
    !chipEnN |-> selExternal);
  a_r2_intonly_no_ext: assert property (@(posedge clk) disable iff (!rstN)
    memMode == 2'b11 |-> (!selExternal && pinOwnIo));
  a_r3_extonly_all_ext: assert property (@(posedge clk) disable iff (!rstN)
    (memMode == 2'b10 && $past(accessValid)) |-> (selExternal && !pinOwnIo && !pinParked));
  a_r4_boot_low_internal: assert property (@(posedge clk) disable iff (!rstN)
    (memMode == 2'b01 && $past(accessValid) && $past(accessAddr) <= BOOT_END) |-> !selExternal);
  a_r5_above_chip_external: assert property (@(posedge clk) disable iff (!rstN)
    (memMode == 2'b00 && $past(accessValid) && $past(accessAddr) > CHIP_END) |-> selExternal);
  a_r8_ext_owns_pins: assert property (@(posedge clk) disable iff (!rstN)
    selExternal |-> (!pinOwnIo && !pinParked));
  a_r7_pin_state_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $countones({pinOwnIo, pinParked, selExternal}) <= 1);
  a_r9_idle_after_gap: assert property (@(posedge clk) disable iff (!rstN)
    !$past(accessValid) |-> (chipEnN && !selExternal && !readZero));
endmodule

bind memModeDecoder memModeDecoderChk #(.ADDR_W(ADDR_W), .BOOT_END(BOOT_END), .CHIP_END(CHIP_END)) chk (.*);

// File: tb/memModeDecoder_test.sv
`timescale 1ns/1ps
module memModeDecoder_test;
  localparam int AW = 21;
  localparam int BOOT = 'h0007FF;
  localparam int CHIP = 'h00FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accessValid = 1'b0;
  logic [AW-1:0] accessAddr = '0;
  logic [1:0] memMode = 2'b11;
  logic busDisable = 1'b0;
  logic selExternal, chipEnN, readZero, pinOwnIo, pinParked;

  int checks = 0;
  int failures = 0;
  bit running = 0;
  string curReq = "R1";

  int mAddr = 0;
  bit mActive = 0;

  always #2.5 clk = ~clk;

  memModeDecoder uut (
    .clk(clk), .rstN(rstN), .accessValid(accessValid), .accessAddr(accessAddr),
    .memMode(memMode), .busDisable(busDisable), .selExternal(selExternal),
    .chipEnN(chipEnN), .readZero(readZero), .pinOwnIo(pinOwnIo), .pinParked(pinParked)
  );

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b mode=%b addr=%h", req, what, act, exp, memMode, mAddr);
    end
  endtask

  task automatic compareAll();
    bit eExt, eZero, eIo, ePark;
    eExt = 0; eZero = 0; eIo = 0; ePark = 0;
    if (mActive) begin
      if (memMode == 2'b10) eExt = 1;
      else if (memMode == 2'b01) eExt = (mAddr > BOOT);
      else if (memMode == 2'b00) eExt = (mAddr > CHIP);
    end
    if (mActive && memMode == 2'b11 && mAddr > CHIP) eZero = 1;
    if (memMode == 2'b11) eIo = 1;
    else if (memMode != 2'b10 && !eExt) begin
      eIo = busDisable;
      ePark = !busDisable;
    end
    check(curReq, "selExternal", selExternal, eExt);
    check("R6", "chipEnN", chipEnN, !eExt);
    check(curReq, "readZero", readZero, eZero);
    check(eExt ? "R8" : "R7", "pinOwnIo", pinOwnIo, eIo);
    check(eExt ? "R8" : "R7", "pinParked", pinParked, ePark);
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mActive = 0;
      mAddr = 0;
    end else begin
      if (accessValid) mAddr = int'(accessAddr);
      mActive = accessValid;
    end
    if (running) begin
      #1 compareAll();
    end
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int addrs[6];
    string tags[4];
    addrs[0] = 0; addrs[1] = BOOT; addrs[2] = BOOT + 1;
    addrs[3] = CHIP; addrs[4] = CHIP + 1; addrs[5] = 'h1FFFFF;
    tags[0] = "R5"; tags[1] = "R4"; tags[2] = "R3"; tags[3] = "R2";
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    memMode = 2'b10;
    curReq = "R1";
    running = 1;
    @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      for (int bd = 0; bd < 2; bd++) begin
        memMode = m[1:0];
        busDisable = bd[0];
        for (int i = 0; i < 6; i++) begin
          curReq = tags[m];
          accessValid = 1'b1;
          accessAddr = addrs[i][AW-1:0];
          @(negedge clk);
          if (i % 3 == 2) begin
            curReq = "R9";
            accessValid = 1'b0;
            accessAddr = 21'h1FFFFF;
            @(negedge clk);
          end
        end
      end
    end
    curReq = "R5";
    memMode = 2'b00;
    accessValid = 1'b1;
    accessAddr = 21'h010000;
    @(negedge clk);
    busDisable = 1'b1;
    memMode = 2'b01;
    curReq = "R4";
    accessAddr = 21'h000400;
    @(negedge clk);
    accessValid = 1'b0;
    curReq = "R9";
    @(negedge clk);
    @(negedge clk);
    running = 0;
    finishRun();
  end
endmodule